// File: doc/BRIEF.md
# Page-mode ROM read controller

This block sits between an internal requester and an asynchronous page-mode ROM on an external bus. The requester presents a start address, a beat count and a write flag. The controller then drives chip select, the read or write strobe, a bus-start strobe and the address bus. It samples read data at the end of each beat's wait period and returns every word with a one-cycle valid pulse.

The first beat of an access works like a normal memory space. It has a long programmable wait, and an external wait input can extend it. On a multi-beat read, the read strobe and chip select stay asserted after the first beat. Only the address moves, by one bus word per beat, and each of those later beats uses a short programmable wait that takes no notice of the external wait input.

A single read and any write use plain normal-space timing, with no page continuation.

Top module: `pagerom_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, all bus strobes are high (inactive), busy is 0, rdata_valid is 0 and bus_wdata_oe is 0.
- R2: A request (req_valid=1) is accepted only when the controller is idle. busy is high from the edge that accepts a request until the edge that negates chip select. A request presented while busy starts no access.
- R3: The first beat lasts max(W+1, m+1) clock cycles. W is cfg_wait_first (0..15). m is the number of consecutive rising edges after acceptance, starting with the first, at which bus_wait_n is sampled low.
- R4: Each second and later beat of a burst lasts exactly B+1 cycles, where B is cfg_wait_burst (0..3). bus_wait_n is ignored during those beats.
- R5: On a read, bus_cs_n and bus_rd_n fall at the same edge and rise at the same edge. bus_rd_n stays low without a break from the first beat through the last, and bus_wr_n stays high.
- R6: bus_bs_n is low for exactly the first cycle of every access and high on all other cycles.
- R7: The first beat drives req_addr. Each later beat drives the previous address plus DATA_W/8 bytes. The change happens on the falling clock edge that follows the rising edge ending the previous beat.
- R8: Read data is sampled at the rising edge that ends each beat. It appears on rdata with rdata_valid high for the one following cycle, in beat order, and it is the word at that beat's address.
- R9: A read of req_beats=1 is a single access: one beat with first-beat timing, then chip select is released. req_beats=0 is treated as 1.
- R10: A write (req_write=1) is always a single beat with first-beat timing, whatever req_beats holds. bus_wr_n is low while chip select is low, bus_rd_n stays high, bus_wdata carries req_wdata with bus_wdata_oe high, and no rdata_valid pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Start byte address |
| req_beats | input | BEAT_W | Number of read beats (0 means 1) |
| req_wdata | input | DATA_W | Write data |
| cfg_wait_first | input | WAITF_W | Wait cycles for the first beat |
| cfg_wait_burst | input | WAITB_W | Wait cycles for each later beat |
| busy | output | 1 | Access in progress |
| rdata_valid | output | 1 | One-cycle pulse marking a returned word |
| rdata | output | DATA_W | Returned read word |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_bs_n | output | 1 | Bus-start strobe, active low |
| bus_wait_n | input | 1 | External wait, low extends the first beat |
| bus_addr | output | ADDR_W | External byte address |
| bus_rdata | input | DATA_W | Data from the ROM |
| bus_wdata | output | DATA_W | Data to the bus on writes |
| bus_wdata_oe | output | 1 | Write data drive enable |

## Verification
Chip select and the strobes change at the rising edge that accepts a request. The address follows half a cycle later, on the next falling edge. Beat one's address therefore runs for max(W+1, m+1) cycles and each later address for B+1 cycles. The rdata_valid pulse for a beat is due in the single cycle after that beat's last cycle. The bench samples every output 15 ns after each rising edge, so all of these are settled. It takes a second address sample 5 ns after the edge to confirm that a new beat's address is still the old one before the falling edge. Expected beats and words are queued by the driver when it issues a request. They are consumed in order as the monitor sees address runs close and valid pulses arrive, so any extra, missing or mistimed result surfaces as a mismatch or as a leftover queue entry.

// File: rtl/pr_pkg.sv
package pr_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FIRST = 2'd1,
      ST_NEXT  = 2'd2
   } pr_state_e;

endpackage

// File: rtl/pr_wait_cnt.sv
module pr_wait_cnt #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             cnt_zero
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign cnt_zero = (cnt_q == '0);

endmodule

// File: rtl/pr_addr_gen.sv
module pr_addr_gen #(
   parameter int ADDR_W     = 26,
   parameter int STEP_BYTES = 4,
   parameter bit FALL_EDGE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              advance,
   output logic [ADDR_W-1:0] bus_addr
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STEP_BYTES);

   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (load) begin
         addr_q <= load_addr;
      end else if (advance) begin
         addr_q <= addr_q + STEP;
      end
   end

   generate
      if (FALL_EDGE) begin : g_fall
         logic [ADDR_W-1:0] addr_fall_q;
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) begin
               addr_fall_q <= '0;
            end else begin
               addr_fall_q <= addr_q;
            end
         end
         assign bus_addr = addr_fall_q;
      end else begin : g_rise
         assign bus_addr = addr_q;
      end
   endgenerate

endmodule

// File: rtl/pr_seq.sv
module pr_seq
   import pr_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int BEAT_W  = 4,
   parameter int WAITB_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [BEAT_W-1:0] req_beats,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              cnt_zero,
   input  logic              bus_wait_n,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              accept,
   output logic              advance,
   output logic              busy,
   output logic              rdata_valid,
   output logic [DATA_W-1:0] rdata,
   output logic              cs_n,
   output logic              rd_n,
   output logic              wr_n,
   output logic              bs_n,
   output logic [DATA_W-1:0] wdata,
   output logic              wdata_oe
);

   localparam int          CYC_W     = 8;
   localparam int unsigned LATER_MAX = (1 << WAITB_W) - 1;

   pr_state_e         state_q;
   logic [BEAT_W-1:0] left_q;
   logic              is_wr_q;
   logic              cs_n_q, rd_n_q, wr_n_q, bs_n_q, oe_q, rv_q;
   logic [DATA_W-1:0] wd_q, rdat_q;
   logic              beat_end;
   logic [CYC_W-1:0]  beat_cyc_q;

   // a beat ends when its wait count is spent; external wait only counts on beat one
   always_comb begin
      unique case (state_q)
         ST_FIRST: beat_end = cnt_zero && bus_wait_n;
         ST_NEXT:  beat_end = cnt_zero;
         default:  beat_end = 1'b0;
      endcase
   end

   assign accept  = (state_q == ST_IDLE) && req_valid;
   assign advance = beat_end && (left_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         left_q  <= '0;
         is_wr_q <= 1'b0;
         cs_n_q  <= 1'b1;
         rd_n_q  <= 1'b1;
         wr_n_q  <= 1'b1;
         bs_n_q  <= 1'b1;
         oe_q    <= 1'b0;
         rv_q    <= 1'b0;
         wd_q    <= '0;
         rdat_q  <= '0;
      end else begin
         rv_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  state_q <= ST_FIRST;
                  is_wr_q <= req_write;
                  cs_n_q  <= 1'b0;
                  bs_n_q  <= 1'b0;
                  rd_n_q  <= req_write;
                  wr_n_q  <= !req_write;
                  oe_q    <= req_write;
                  wd_q    <= req_wdata;
                  if (req_write || req_beats == '0) begin
                     left_q <= '0;
                  end else begin
                     left_q <= req_beats - 1'b1;
                  end
               end
            end
            ST_FIRST, ST_NEXT: begin
               bs_n_q <= 1'b1;
               if (beat_end) begin
                  if (!is_wr_q) begin
                     rdat_q <= bus_rdata;
                     rv_q   <= 1'b1;
                  end
                  if (left_q != '0) begin
                     state_q <= ST_NEXT;
                     left_q  <= left_q - 1'b1;
                  end else begin
                     state_q <= ST_IDLE;
                     cs_n_q  <= 1'b1;
                     rd_n_q  <= 1'b1;
                     wr_n_q  <= 1'b1;
                     oe_q    <= 1'b0;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // cycles spent in the current beat, kept for the checks below
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat_cyc_q <= '0;
      end else if (accept || advance) begin
         beat_cyc_q <= '0;
      end else if (state_q != ST_IDLE && beat_cyc_q != '1) begin
         beat_cyc_q <= beat_cyc_q + 1'b1;
      end
   end

   assign busy        = !cs_n_q;
   assign rdata_valid = rv_q;
   assign rdata       = rdat_q;
   assign cs_n        = cs_n_q;
   assign rd_n        = rd_n_q;
   assign wr_n        = wr_n_q;
   assign bs_n        = bs_n_q;
   assign wdata       = wd_q;
   assign wdata_oe    = oe_q;

   AST_BS_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      !bs_n_q |=> bs_n_q); // R6
   AST_BS_OPENS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      !bs_n_q |-> $fell(cs_n_q)); // R6
   AST_ACCEPT_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n_q) |-> $past(state_q) == ST_IDLE); // R2
   AST_RD_HELD_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_NEXT) |-> (!rd_n_q && !cs_n_q && wr_n_q)); // R5
   AST_READ_STARTS_WITH_CS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_n_q) |-> $fell(cs_n_q)); // R5
   AST_STROBES_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n_q) |-> (rd_n_q && wr_n_q && !oe_q)); // R5
   AST_LATER_BEAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_NEXT) |-> (32'(beat_cyc_q) <= LATER_MAX)); // R4
   AST_VALID_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      rv_q |-> ($past(cnt_zero) && !$past(rd_n_q))); // R8
   AST_WRITE_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n_q |-> (state_q == ST_FIRST)); // R10

endmodule

// File: rtl/pagerom_ctrl.sv
module pagerom_ctrl #(
   parameter int ADDR_W    = 26,
   parameter int DATA_W    = 32,
   parameter int BEAT_W    = 4,
   parameter int WAITF_W   = 4,
   parameter int WAITB_W   = 2,
   parameter bit FALL_ADDR = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [BEAT_W-1:0]  req_beats,
   input  logic [DATA_W-1:0]  req_wdata,
   input  logic [WAITF_W-1:0] cfg_wait_first,
   input  logic [WAITB_W-1:0] cfg_wait_burst,
   output logic               busy,
   output logic               rdata_valid,
   output logic [DATA_W-1:0]  rdata,
   output logic               bus_cs_n,
   output logic               bus_rd_n,
   output logic               bus_wr_n,
   output logic               bus_bs_n,
   input  logic               bus_wait_n,
   output logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_rdata,
   output logic [DATA_W-1:0]  bus_wdata,
   output logic               bus_wdata_oe
);

   localparam int CNT_W      = (WAITF_W > WAITB_W) ? WAITF_W : WAITB_W;
   localparam int STEP_BYTES = DATA_W / 8;

   initial begin
      assert (DATA_W >= 8 && DATA_W % 8 == 0)
         else $error("DATA_W must be a whole number of bytes");
      assert (BEAT_W >= 1 && ADDR_W >= 2)
         else $error("BEAT_W and ADDR_W too small");
      assert (WAITF_W >= 1 && WAITB_W >= 1)
         else $error("wait fields need at least one bit");
   end

   logic             seq_accept;
   logic             seq_advance;
   logic             cnt_zero;
   logic [CNT_W-1:0] cnt_load_val;

   assign cnt_load_val = seq_accept ? CNT_W'(cfg_wait_first) : CNT_W'(cfg_wait_burst);

   pr_wait_cnt #(
      .CNT_W (CNT_W)
   ) u_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (seq_accept || seq_advance),
      .load_val (cnt_load_val),
      .cnt_zero (cnt_zero)
   );

   pr_addr_gen #(
      .ADDR_W     (ADDR_W),
      .STEP_BYTES (STEP_BYTES),
      .FALL_EDGE  (FALL_ADDR)
   ) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (seq_accept),
      .load_addr (req_addr),
      .advance   (seq_advance),
      .bus_addr  (bus_addr)
   );

   pr_seq #(
      .DATA_W  (DATA_W),
      .BEAT_W  (BEAT_W),
      .WAITB_W (WAITB_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_write   (req_write),
      .req_beats   (req_beats),
      .req_wdata   (req_wdata),
      .cnt_zero    (cnt_zero),
      .bus_wait_n  (bus_wait_n),
      .bus_rdata   (bus_rdata),
      .accept      (seq_accept),
      .advance     (seq_advance),
      .busy        (busy),
      .rdata_valid (rdata_valid),
      .rdata       (rdata),
      .cs_n        (bus_cs_n),
      .rd_n        (bus_rd_n),
      .wr_n        (bus_wr_n),
      .bs_n        (bus_bs_n),
      .wdata       (bus_wdata),
      .wdata_oe    (bus_wdata_oe)
   );

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_cs_n && !$past(bus_cs_n) && bus_addr != $past(bus_addr))
      |-> bus_addr == $past(bus_addr) + ADDR_W'(STEP_BYTES)); // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      bus_cs_n |-> (bus_rd_n && bus_wr_n && bus_bs_n && !bus_wdata_oe)); // R1

endmodule

// File: tb/pagerom_ctrl_tb.sv
module pagerom_ctrl_tb;

   localparam int AW = 26;
   localparam int DW = 32;
   localparam int BTW = 4;
   localparam int WFW = 4;
   localparam int WBW = 2;

   logic           clk;
   logic           rst_n;
   logic           req_valid, req_write;
   logic [AW-1:0]  req_addr;
   logic [BTW-1:0] req_beats;
   logic [DW-1:0]  req_wdata;
   logic [WFW-1:0] cfg_wait_first;
   logic [WBW-1:0] cfg_wait_burst;
   logic           busy, rdata_valid;
   logic [DW-1:0]  rdata;
   logic           bus_cs_n, bus_rd_n, bus_wr_n, bus_bs_n, bus_wait_n;
   logic [AW-1:0]  bus_addr;
   logic [DW-1:0]  bus_rdata, bus_wdata;
   logic           bus_wdata_oe;

   typedef struct {
      logic [AW-1:0] addr;
      int            len;
      string         tag;
   } beat_t;

   beat_t         beat_q[$];
   logic [DW-1:0] data_q[$];
   logic [DW-1:0] exp_wdata;
   int            checks;
   int            fails;
   bit            finished;

   function automatic logic [DW-1:0] rom_word(logic [AW-1:0] a);
      return (DW'(a) * 32'h9E3779B1) ^ 32'h1234ABCD;
   endfunction

   assign bus_rdata = (!bus_cs_n && !bus_rd_n) ? rom_word(bus_addr) : 32'hDEADBEEF;

   pagerom_ctrl u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_valid      (req_valid),
      .req_write      (req_write),
      .req_addr       (req_addr),
      .req_beats      (req_beats),
      .req_wdata      (req_wdata),
      .cfg_wait_first (cfg_wait_first),
      .cfg_wait_burst (cfg_wait_burst),
      .busy           (busy),
      .rdata_valid    (rdata_valid),
      .rdata          (rdata),
      .bus_cs_n       (bus_cs_n),
      .bus_rd_n       (bus_rd_n),
      .bus_wr_n       (bus_wr_n),
      .bus_bs_n       (bus_bs_n),
      .bus_wait_n     (bus_wait_n),
      .bus_addr       (bus_addr),
      .bus_rdata      (bus_rdata),
      .bus_wdata      (bus_wdata),
      .bus_wdata_oe   (bus_wdata_oe)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic close_run(input logic [AW-1:0] a, input int len);
      beat_t e;
      if (beat_q.size() == 0) begin
         chk(1'b0, "R2", "beat with no request", longint'(a), 0);
      end else begin
         e = beat_q.pop_front();
         chk(a == e.addr, "R7", "beat address", longint'(a), longint'(e.addr));
         chk(len == e.len, e.tag, "beat length", len, e.len);
      end
   endtask

   // monitor: rebuilds beats from address runs and pops the scoreboard
   initial begin
      bit            prev_low;
      bit            txn_wr;
      int            run_len;
      logic [AW-1:0] run_addr;
      logic [AW-1:0] early;
      logic [DW-1:0] e;
      prev_low = 1'b0;
      txn_wr   = 1'b0;
      run_len  = 0;
      run_addr = '0;
      @(posedge rst_n);
      forever begin
         @(posedge clk);
         #5 early = bus_addr;
         #10;
         chk(busy == !bus_cs_n, "R2", "busy vs chip select", busy, !bus_cs_n);
         if (!bus_cs_n) begin
            if (!prev_low) begin
               chk(!bus_bs_n, "R6", "bus start on first cycle", bus_bs_n, 0);
               txn_wr   = !bus_wr_n;
               run_addr = bus_addr;
               run_len  = 1;
            end else begin
               chk(bus_bs_n, "R6", "bus start after first cycle", bus_bs_n, 1);
               if (bus_addr == run_addr) begin
                  run_len++;
               end else begin
                  chk(early == run_addr, "R7", "address moved before falling edge",
                      longint'(early), longint'(run_addr));
                  close_run(run_addr, run_len);
                  run_addr = bus_addr;
                  run_len  = 1;
               end
            end
            if (txn_wr) begin
               chk(!bus_wr_n && bus_rd_n, "R10", "write strobes", {bus_wr_n, bus_rd_n}, 2'b01);
               chk(bus_wdata_oe && bus_wdata == exp_wdata, "R10", "write data",
                   longint'(bus_wdata), longint'(exp_wdata));
            end else begin
               chk(!bus_rd_n && bus_wr_n, "R5", "read strobe held", {bus_rd_n, bus_wr_n}, 2'b01);
            end
         end else if (prev_low) begin
            close_run(run_addr, run_len);
            chk(bus_rd_n && bus_wr_n, "R5", "strobes released with cs", {bus_rd_n, bus_wr_n}, 2'b11);
         end
         if (rdata_valid) begin
            if (data_q.size() == 0) begin
               chk(1'b0, "R10", "unexpected valid", longint'(rdata), 0);
            end else begin
               e = data_q.pop_front();
               chk(rdata == e, "R8", "read word", longint'(rdata), longint'(e));
            end
         end
         prev_low = !bus_cs_n;
      end
   end

   // driver: queues the expected beats then issues one request
   task automatic run_txn(input logic [AW-1:0] a, input int beats, input bit wr,
                          input logic [DW-1:0] wd, input int w, input int bw,
                          input int m, input bit late_wait, input bit poke);
      int nb;
      int k;
      nb = wr ? 1 : ((beats == 0) ? 1 : beats);
      k  = (w > m) ? w + 1 : m + 1;
      for (int b = 0; b < nb; b++) begin
         beat_t e;
         e.addr = a + AW'(4 * b);
         e.len  = (b == 0) ? k : bw + 1;
         e.tag  = (b == 0) ? "R3" : "R4";
         beat_q.push_back(e);
         if (!wr) data_q.push_back(rom_word(e.addr));
      end
      exp_wdata = wd;
      @(negedge clk);
      cfg_wait_first = WFW'(w);
      cfg_wait_burst = WBW'(bw);
      req_addr  = a;
      req_beats = BTW'(beats);
      req_write = wr;
      req_wdata = wd;
      req_valid = 1'b1;
      bus_wait_n = (m > 0) ? 1'b0 : 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      if (poke) begin
         req_addr  = a ^ AW'(24'h0F_0000);
         req_write = 1'b0;
         req_valid = 1'b1;
         repeat (2) @(negedge clk);
         req_valid = 1'b0;
      end else begin
         if (m > 0) begin
            repeat (m) @(posedge clk);
            @(negedge clk);
            bus_wait_n = 1'b1;
         end
         if (late_wait && nb > 1) begin
            repeat (k - m) @(posedge clk);
            @(negedge clk);
            bus_wait_n = 1'b0;
         end
      end
      do begin
         @(posedge clk);
         #15;
      end while (!bus_cs_n);
      bus_wait_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic finish_run;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL R2 watchdog actual=hung expected=idle");
         finish_run();
      end
   end

   initial begin
      checks = 0;
      fails = 0;
      finished = 1'b0;
      rst_n = 1'b0;
      req_valid = 1'b0;
      req_write = 1'b0;
      req_addr = '0;
      req_beats = '0;
      req_wdata = '0;
      cfg_wait_first = '0;
      cfg_wait_burst = '0;
      bus_wait_n = 1'b1;
      exp_wdata = '0;
      repeat (3) @(posedge clk);
      #15;
      chk(bus_cs_n && bus_rd_n && bus_wr_n && bus_bs_n, "R1", "strobes in reset",
          {bus_cs_n, bus_rd_n, bus_wr_n, bus_bs_n}, 4'hF);
      chk(!busy && !rdata_valid && !bus_wdata_oe, "R1", "status in reset",
          {busy, rdata_valid, bus_wdata_oe}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
      #15;
      chk(bus_cs_n && bus_rd_n && bus_wr_n && bus_bs_n, "R1", "strobes after reset",
          {bus_cs_n, bus_rd_n, bus_wr_n, bus_bs_n}, 4'hF);
      chk(!busy && !rdata_valid, "R1", "status after reset", {busy, rdata_valid}, 0);

      run_txn(26'h0000040, 1, 1'b0, '0, 0, 0, 0, 1'b0, 1'b0);         // R9 fast single read
      run_txn(26'h0000104, 1, 1'b0, '0, 6, 2, 3, 1'b0, 1'b0);         // R9 single read, R3 wait
      run_txn(26'h0000100, 4, 1'b0, '0, 3, 1, 0, 1'b0, 1'b0);         // R4 burst
      run_txn(26'h0001000, 8, 1'b0, '0, 15, 3, 2, 1'b0, 1'b0);        // R3 long first beat
      run_txn(26'h0002000, 3, 1'b0, '0, 1, 0, 4, 1'b1, 1'b0);         // R3 extended, R4 wait ignored
      run_txn(26'h0003000, 6, 1'b0, '0, 2, 2, 0, 1'b1, 1'b0);         // R4 wait ignored
      run_txn(26'h0004000, 0, 1'b0, '0, 1, 3, 0, 1'b0, 1'b0);         // R9 zero beats means one
      run_txn(26'h0005000, 5, 1'b1, 32'hCAFE_0123, 2, 3, 3, 1'b0, 1'b0); // R10 write ignores beats
      run_txn(26'h0005004, 1, 1'b1, 32'h5555_AAAA, 0, 0, 0, 1'b0, 1'b0); // R10 fast write
      run_txn(26'h0006000, 2, 1'b0, '0, 5, 1, 0, 1'b0, 1'b1);         // R2 request while busy
      run_txn(26'h0007ff0, 4, 1'b0, '0, 0, 0, 0, 1'b0, 1'b0);         // R8 back-to-back words

      repeat (4) @(negedge clk);
      chk(beat_q.size() == 0, "R8", "beats left over", beat_q.size(), 0);
      chk(data_q.size() == 0, "R8", "words left over", data_q.size(), 0);
      chk(bus_cs_n && !busy, "R2", "idle at end", {bus_cs_n, busy}, 2'b10);
      finished = 1'b1;
      finish_run();
   end

endmodule